// File: doc/BRIEF.md
# Coherent Interconnect Packet Framer

This block sits between a memory-interconnect transaction layer and a point-to-point link that carries 16-bit symbols. It has two halves that run at the same time and do not share any state. The transmit half accepts a header descriptor. It checks that the payload length is one of the allowed sizes, then emits eight header symbols, the payload symbols taken from a valid/ready source, and a closing 16-bit CRC symbol. The receive half watches the incoming symbol stream and finds the packet boundaries from the size code carried in the first header symbol. It marks which symbols are payload, and at the end of each packet it reports whether the CRC matched, together with the destination node, the packet type and the size code.

Requests and responses use the same layout and differ only in the one-bit type flag. The destination node is the upper sixteen bits of the 64-bit address.

Top module: `pkt_link_framer`

## Requirements
- R1: A transmitted header is 8 symbols. Symbol 0 is {type, size code[1:0], 13'b0}. Symbols 1 to 4 carry the 64-bit address, most significant half-word first. Symbols 5 to 7 carry the 48-bit auxiliary field, most significant first.
- R2: hdr_len is given in bytes. The size code is 00 for 0 bytes, 01 for 16, 10 for 64 and 11 for 256. After the header come exactly 0, 8, 32 or 128 payload symbols, each equal to the pld_data word accepted, in order.
- R3: A descriptor whose hdr_len is any other value is consumed. tx_len_err pulses for one cycle in the following cycle, and no symbol is emitted for that descriptor.
- R4: The last symbol of each packet is a CRC over all header and payload symbols. It uses polynomial 0x1021, preset 0xFFFF, symbols fed MSB first, and no final inversion.
- R5: While tx_valid is high and tx_ready is low, tx_valid stays high and tx_data does not change. pld_ready is high only during the payload phase, and only when tx_ready is high.
- R6: hdr_ready is high exactly when no packet is in flight, and tx_valid is never high at the same time as hdr_ready.
- R7: The receiver takes bits 14:13 of received header symbol 0 as the size code. rx_pld_valid is high exactly for the received symbols that fall in the payload.
- R8: In the cycle after the CRC symbol is received, rx_done pulses for one cycle. In the same cycle rx_crc_err is high if that symbol differs from the CRC of the received header and payload.
- R9: When rx_done is high, rx_node equals received header symbol 1 (address bits 63:48), rx_type equals bit 15 of symbol 0, and rx_size equals the size code.
- R10: Transmit and receive traffic proceed concurrently without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | Descriptor offered |
| hdr_ready | output | 1 | Transmitter idle, descriptor taken |
| hdr_type | input | 1 | Request/response flag |
| hdr_len | input | 9 | Payload length in bytes |
| hdr_addr | input | 64 | Target address, node in bits 63:48 |
| hdr_aux | input | 48 | Auxiliary header field |
| tx_len_err | output | 1 | Illegal length pulse |
| pld_valid | input | 1 | Payload word offered |
| pld_ready | output | 1 | Payload word taken |
| pld_data | input | 16 | Payload word |
| tx_valid | output | 1 | Outgoing symbol valid |
| tx_ready | input | 1 | Link accepts symbol |
| tx_data | output | 16 | Outgoing symbol |
| rx_valid | input | 1 | Incoming symbol valid |
| rx_data | input | 16 | Incoming symbol |
| rx_pld_valid | output | 1 | Incoming symbol is payload |
| rx_done | output | 1 | Packet end pulse |
| rx_crc_err | output | 1 | CRC mismatch pulse |
| rx_node | output | 16 | Destination node of last header |
| rx_type | output | 1 | Type flag of last header |
| rx_size | output | 2 | Size code of last header |

## Verification
Transmission is tried with each legal length, once with the link always ready and once with random back-pressure and payload bubbles. The always-ready runs isolate symbol order and CRC. The back-pressure run shows whether stalls corrupt held data or skip a payload word. Lengths just off the legal set (20 and 255) show that only the exact sizes pass. On the receive side, all four size codes arrive with gaps in rx_valid while transmit traffic runs at the same time. A frame with one flipped CRC bit shows that the error flag follows the data rather than the framing.

// File: rtl/pkt_link_framer.sv
module pkt_link_framer #(
  parameter logic [15:0] CRC_POLY = 16'h1021,
  parameter logic [15:0] CRC_INIT = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hdr_valid,
  output logic        hdr_ready,
  input  logic        hdr_type,
  input  logic [8:0]  hdr_len,
  input  logic [63:0] hdr_addr,
  input  logic [47:0] hdr_aux,
  output logic        tx_len_err,
  input  logic        pld_valid,
  output logic        pld_ready,
  input  logic [15:0] pld_data,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [15:0] tx_data,
  input  logic        rx_valid,
  input  logic [15:0] rx_data,
  output logic        rx_pld_valid,
  output logic        rx_done,
  output logic        rx_crc_err,
  output logic [15:0] rx_node,
  output logic        rx_type,
  output logic [1:0]  rx_size
);
  localparam int HDR_SYMS = 8;
  localparam int CNT_W    = 7;

  function automatic logic [15:0] crc_next(input logic [15:0] c, input logic [15:0] d);
    logic [15:0] r;
    logic fb;
    r = c;
    for (int i = 15; i >= 0; i--) begin
      fb = r[15] ^ d[i];
      r  = {r[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
    end
    return r;
  endfunction

  function automatic logic [CNT_W:0] pld_last(input logic [1:0] sz);
    case (sz)
      2'd1:    return 8'd7;
      2'd2:    return 8'd31;
      default: return 8'd127;
    endcase
  endfunction

  typedef enum logic [1:0] {T_IDLE, T_HDR, T_PLD, T_CRC} tx_st_t;
  typedef enum logic [1:0] {R_HDR, R_PLD, R_CRC} rx_st_t;

  tx_st_t            tx_st;
  logic [CNT_W-1:0]  tx_cnt;
  logic [15:0]       tx_crc;
  logic              t_type;
  logic [1:0]        t_size;
  logic [63:0]       t_addr;
  logic [47:0]       t_aux;
  logic [15:0]       hdr_sym;
  logic              len_ok;
  logic [1:0]        len_code;
  logic              tx_fire;

  always_comb begin
    len_ok   = 1'b1;
    len_code = 2'd0;
    case (hdr_len)
      9'd0:    len_code = 2'd0;
      9'd16:   len_code = 2'd1;
      9'd64:   len_code = 2'd2;
      9'd256:  len_code = 2'd3;
      default: len_ok   = 1'b0;
    endcase
  end

  always_comb begin
    case (tx_cnt[2:0])
      3'd0:    hdr_sym = {t_type, t_size, 13'b0};
      3'd1:    hdr_sym = t_addr[63:48];
      3'd2:    hdr_sym = t_addr[47:32];
      3'd3:    hdr_sym = t_addr[31:16];
      3'd4:    hdr_sym = t_addr[15:0];
      3'd5:    hdr_sym = t_aux[47:32];
      3'd6:    hdr_sym = t_aux[31:16];
      default: hdr_sym = t_aux[15:0];
    endcase
  end

  assign hdr_ready = (tx_st == T_IDLE);
  assign pld_ready = (tx_st == T_PLD) && tx_ready;
  assign tx_valid  = (tx_st == T_HDR) || (tx_st == T_CRC) || ((tx_st == T_PLD) && pld_valid);
  assign tx_data   = (tx_st == T_PLD) ? pld_data : (tx_st == T_CRC) ? tx_crc : hdr_sym;
  assign tx_fire   = tx_valid && tx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_st      <= T_IDLE;
      tx_cnt     <= '0;
      tx_crc     <= CRC_INIT;
      tx_len_err <= 1'b0;
      t_type     <= 1'b0;
      t_size     <= 2'd0;
      t_addr     <= '0;
      t_aux      <= '0;
    end else begin
      tx_len_err <= 1'b0;
      case (tx_st)
        T_IDLE: if (hdr_valid) begin
          if (len_ok) begin
            t_type <= hdr_type;
            t_size <= len_code;
            t_addr <= hdr_addr;
            t_aux  <= hdr_aux;
            tx_cnt <= '0;
            tx_crc <= CRC_INIT;
            tx_st  <= T_HDR;
          end else begin
            tx_len_err <= 1'b1;
          end
        end
        T_HDR: if (tx_fire) begin
          tx_crc <= crc_next(tx_crc, tx_data);
          if (tx_cnt == CNT_W'(HDR_SYMS - 1)) begin
            tx_cnt <= '0;
            tx_st  <= (t_size == 2'd0) ? T_CRC : T_PLD;
          end else begin
            tx_cnt <= tx_cnt + 1'b1;
          end
        end
        T_PLD: if (tx_fire) begin
          tx_crc <= crc_next(tx_crc, tx_data);
          if ({1'b0, tx_cnt} == pld_last(t_size)) begin
            tx_cnt <= '0;
            tx_st  <= T_CRC;
          end else begin
            tx_cnt <= tx_cnt + 1'b1;
          end
        end
        default: if (tx_fire) tx_st <= T_IDLE;
      endcase
    end
  end

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_ready |-> !tx_valid);
  p_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && hdr_ready && !len_ok) |=> (tx_len_err && hdr_ready));

  rx_st_t            rx_st;
  logic [CNT_W-1:0]  rx_cnt;
  logic [15:0]       rx_crc;
  logic [15:0]       rx_crc_in;

  assign rx_pld_valid = rx_valid && (rx_st == R_PLD);
  assign rx_crc_in    = (rx_st == R_HDR && rx_cnt == '0) ? CRC_INIT : rx_crc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_st      <= R_HDR;
      rx_cnt     <= '0;
      rx_crc     <= CRC_INIT;
      rx_done    <= 1'b0;
      rx_crc_err <= 1'b0;
      rx_node    <= '0;
      rx_type    <= 1'b0;
      rx_size    <= 2'd0;
    end else begin
      rx_done    <= 1'b0;
      rx_crc_err <= 1'b0;
      if (rx_valid) begin
        case (rx_st)
          R_HDR: begin
            rx_crc <= crc_next(rx_crc_in, rx_data);
            if (rx_cnt == '0) {rx_type, rx_size} <= rx_data[15:13];
            if (rx_cnt == CNT_W'(1)) rx_node <= rx_data;
            if (rx_cnt == CNT_W'(HDR_SYMS - 1)) begin
              rx_cnt <= '0;
              rx_st  <= (rx_size == 2'd0) ? R_CRC : R_PLD;
            end else begin
              rx_cnt <= rx_cnt + 1'b1;
            end
          end
          R_PLD: begin
            rx_crc <= crc_next(rx_crc, rx_data);
            if ({1'b0, rx_cnt} == pld_last(rx_size)) begin
              rx_cnt <= '0;
              rx_st  <= R_CRC;
            end else begin
              rx_cnt <= rx_cnt + 1'b1;
            end
          end
          default: begin
            rx_done    <= 1'b1;
            rx_crc_err <= (rx_data != rx_crc);
            rx_cnt     <= '0;
            rx_st      <= R_HDR;
          end
        endcase
      end
    end
  end

  p_err_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_crc_err |-> rx_done);
  p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);
  p_pld_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> !rx_pld_valid);
endmodule

// File: tb/pkt_link_framer_tb.sv
module pkt_link_framer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hdr_valid = 1'b0, hdr_ready, hdr_type = 1'b0;
  logic [8:0]  hdr_len = '0;
  logic [63:0] hdr_addr = '0;
  logic [47:0] hdr_aux = '0;
  logic        tx_len_err, pld_valid = 1'b0, pld_ready;
  logic [15:0] pld_data = '0;
  logic        tx_valid, tx_ready = 1'b1;
  logic [15:0] tx_data;
  logic        rx_valid = 1'b0;
  logic [15:0] rx_data = '0;
  logic        rx_pld_valid, rx_done, rx_crc_err, rx_type;
  logic [15:0] rx_node;
  logic [1:0]  rx_size;

  int checks = 0, failures = 0;
  bit rdy_random = 1'b0;
  logic [15:0] exp_sym[$];
  string       exp_tag[$];
  bit          prev_stall = 1'b0;
  logic [15:0] prev_data = '0;

  always #4 clk = ~clk;

  pkt_link_framer u_dut (.*);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [15:0] syms[$]);
    logic [15:0] acc = 16'hFFFF;
    foreach (syms[k])
      for (int b = 15; b >= 0; b--)
        acc = (acc[15] ^ syms[k][b]) ? ((acc << 1) ^ 16'h1021) : (acc << 1);
    return acc;
  endfunction

  always @(posedge clk) begin
    #1;
    tx_ready <= rdy_random ? ($urandom_range(3) != 0) : 1'b1;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (hdr_ready && tx_valid) check("R6 tx_valid while idle", 1, 0);
      if (prev_stall) begin
        check("R5 valid held in stall", tx_valid, 1);
        check("R5 data held in stall", tx_data, prev_data);
      end
      if (pld_ready && !tx_ready) check("R5 pld_ready without tx_ready", 1, 0);
      if (tx_valid && tx_ready) begin
        if (exp_sym.size() == 0) check("R3 unexpected symbol", tx_data, 16'hxxxx);
        else check(exp_tag.pop_front(), tx_data, exp_sym.pop_front());
      end
      prev_stall = tx_valid && !tx_ready;
      prev_data  = tx_data;
    end
  end

  function automatic logic [1:0] code_of(input int len);
    return (len == 16) ? 2'd1 : (len == 64) ? 2'd2 : (len == 256) ? 2'd3 : 2'd0;
  endfunction

  task automatic tx_send(input bit typ, input int len, input logic [63:0] addr,
                         input logic [47:0] aux, input bit bubbles);
    bit legal = (len == 0 || len == 16 || len == 64 || len == 256);
    logic [15:0] syms[$];
    logic [15:0] words[$];
    if (legal) begin
      syms.push_back({typ, code_of(len), 13'b0});
      for (int k = 3; k >= 0; k--) syms.push_back(addr[k*16 +: 16]);
      for (int k = 2; k >= 0; k--) syms.push_back(aux[k*16 +: 16]);
      for (int k = 0; k < len / 2; k++) begin
        words.push_back(16'(addr[15:0] * 3 + k * 16'h0107));
        syms.push_back(words[k]);
      end
      foreach (syms[k]) begin
        exp_sym.push_back(syms[k]);
        exp_tag.push_back(k < 8 ? "R1 header symbol" : "R2 payload symbol");
      end
      exp_sym.push_back(ref_crc(syms));
      exp_tag.push_back("R4 crc symbol");
    end
    @(posedge clk); #1;
    hdr_valid = 1; hdr_type = typ; hdr_len = 9'(len); hdr_addr = addr; hdr_aux = aux;
    forever begin @(negedge clk); if (hdr_ready) break; end
    @(posedge clk); #1;
    hdr_valid = 0;
    @(negedge clk);
    check(legal ? "R2 no len_err on legal length" : "R3 len_err pulse", tx_len_err, !legal);
    if (!legal) check("R3 nothing sent", {hdr_ready, tx_valid}, 2'b10);
    foreach (words[k]) begin
      pld_data = words[k];
      pld_valid = 1;
      forever begin if (pld_ready) break; @(negedge clk); end
      @(posedge clk); #1;
      pld_valid = 0;
      if (bubbles && k % 3 == 1) begin @(posedge clk); #1; end
      @(negedge clk);
    end
    while (exp_sym.size() != 0) @(negedge clk);
  endtask

  task automatic rx_send(input bit typ, input logic [1:0] sz, input logic [15:0] node,
                         input bit corrupt);
    logic [15:0] syms[$];
    int npl = (sz == 0) ? 0 : (sz == 1) ? 8 : (sz == 2) ? 32 : 128;
    logic [15:0] c;
    syms.push_back({typ, sz, 13'h0abc});
    syms.push_back(node);
    for (int k = 0; k < 6; k++) syms.push_back(16'(16'h3100 + k * 16'h0011));
    for (int k = 0; k < npl; k++) syms.push_back(16'(node ^ (k * 16'h0203)));
    c = ref_crc(syms);
    syms.push_back(corrupt ? (c ^ 16'h0040) : c);
    foreach (syms[k]) begin
      @(posedge clk); #1;
      rx_valid = 1; rx_data = syms[k];
      @(negedge clk);
      check("R7 payload marker", rx_pld_valid, (k >= 8 && k < 8 + npl));
      check("R8 no early done", rx_done, 0);
      if (k % 5 == 2) begin
        @(posedge clk); #1; rx_valid = 0;
      end
    end
    @(posedge clk); #1;
    rx_valid = 0;
    @(negedge clk);
    check("R8 R10 done pulse", rx_done, 1);
    check("R8 crc error flag", rx_crc_err, corrupt);
    check("R9 node", rx_node, node);
    check("R9 type and size", {rx_type, rx_size}, {typ, sz});
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        check("R6 reset idle", {hdr_ready, tx_valid, pld_ready}, 3'b100);
        check("R8 reset no done", {rx_done, rx_crc_err}, 2'b00);
        fork
          begin
            tx_send(1'b0, 0,   64'h0012_3456_789a_bcde, 48'h1111_2222_3333, 0);
            tx_send(1'b1, 16,  64'hfffe_0000_0000_0010, 48'habcd_ef01_2345, 0);
            tx_send(1'b0, 20,  64'h1,                   48'h0,              0);
            tx_send(1'b0, 64,  64'h0007_aaaa_5555_0040, 48'h0f0f_f0f0_0ff0, 0);
            tx_send(1'b1, 255, 64'h2,                   48'h0,              0);
            rdy_random = 1;
            tx_send(1'b1, 256, 64'h8001_1234_0000_0100, 48'h9999_8888_7777, 1);
            tx_send(1'b0, 16,  64'h0042_0000_0000_0000, 48'h5a5a_a5a5_5a5a, 1);
            rdy_random = 0;
          end
          begin
            rx_send(1'b0, 2'd0, 16'h0001, 0);
            rx_send(1'b1, 2'd1, 16'hbeef, 0);
            rx_send(1'b0, 2'd2, 16'h1234, 1);
            rx_send(1'b1, 2'd3, 16'hffff, 0);
            rx_send(1'b0, 2'd1, 16'h0000, 1);
          end
        join
      end
      begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule